// File: doc/BRIEF.md
# Four-Mode Addressable Output Latch

This block holds eight output bits behind a single serial data bit and a three-bit select. Two active-low controls choose what the next rising clock edge does:
- write the selected bit and keep the rest,
- keep all bits,
- show a one-of-eight pattern gated by the data bit,
- clear every bit.

It is a clocked model of a level-sensitive addressable latch. Every mode decision and every output change happens on the rising edge of `clk`, and an asynchronous power-on reset sets all outputs to zero.

A typical use is serial-to-parallel loading: hold write mode, step the select from 0 to 7 and present one data bit per cycle. The full byte then appears on the parallel outputs. The same pins, with the clear control also asserted, turn the block into an active-high decoder: the data bit high lights exactly the selected output.

The block moves no data stream, so it has no valid/ready handshake. Every pin is a plain level that is sampled on each rising edge, and the block never applies back-pressure.

Top module: `qm_latch`

## Requirements
- R1: While `rst_n` is low, all eight outputs are zero, and they stay zero until a mode changes them after `rst_n` has returned high.
- R2: With `wr_en_n`=0 and `clr_n`=1 (write mode), the rising edge copies `data_in` into the selected output, and every other output keeps its value.
- R3: With `wr_en_n`=1 and `clr_n`=1 (hold mode), the rising edge changes no output, whatever `data_in` and `sel` are.
- R4: With `wr_en_n`=0 and `clr_n`=0 (decode mode), after the edge the selected output equals `data_in` and all other outputs are zero.
- R5: With `wr_en_n`=1 and `clr_n`=0 (clear mode), after the edge all outputs are zero, whatever `data_in` and `sel` are.
- R6: `sel` is an unsigned binary number with bit 0 as its least significant bit, and the value n addresses `outs[n]`.
- R7: Outputs change only on a rising edge of `clk` (or on reset). A change of any input between edges leaves `outs` unchanged until the next edge.
- R8: Going from decode mode to hold mode keeps the last decode pattern, which has at most one bit set.
- R9: Eight write-mode cycles with `sel` stepping 0 to 7 leave the serially presented bits on `outs[0]` to `outs[7]` in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en_n | input | 1 | Write enable, active low |
| clr_n | input | 1 | Conditional clear, active low; decode mode when `wr_en_n` is also low |
| data_in | input | 1 | Shared data bit |
| sel | input | 3 | Output select, binary, bit 0 least significant |
| outs | output | 8 | Parallel stored outputs |

## Verification
The stored bits are the outputs themselves, so a wrong internal state shows at the ports in the cycle right after the edge that caused it. A write that lands on the wrong bit or disturbs a neighbour makes a whole-byte mismatch in the next comparison. A decode pattern with a stray high bit, or a hold that drifts, shows one edge later and stays visible until a write, decode or clear covers it. The serial load and the decode sweep touch every select value, so any error in the select decoding shows up within eight cycles.

// File: rtl/qm_latch_pkg.sv
package qm_latch_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE  = 2'd0,
    MODE_HOLD   = 2'd1,
    MODE_DECODE = 2'd2,
    MODE_CLEAR  = 2'd3
  } qm_mode_e;

endpackage

// File: rtl/qm_mode_sel.sv
module qm_mode_sel
  import qm_latch_pkg::*;
(
  input  logic     wr_en_n,
  input  logic     clr_n,
  output qm_mode_e mode
);

  // The two active-low controls pick one of four modes.
  always_comb begin
    unique case ({wr_en_n, clr_n})
      2'b01:   mode = MODE_WRITE;
      2'b11:   mode = MODE_HOLD;
      2'b00:   mode = MODE_DECODE;
      default: mode = MODE_CLEAR;
    endcase
  end

endmodule

// File: rtl/qm_addr_dec.sv
module qm_addr_dec #(
  parameter int NUM_OUT = 8,
  parameter int ADDR_W  = 3
) (
  input  logic [ADDR_W-1:0]  sel,
  output logic [NUM_OUT-1:0] hit
);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_hit
    assign hit[i] = (sel == ADDR_W'(i));
  end

endmodule

// File: rtl/qm_out_bank.sv
module qm_out_bank
  import qm_latch_pkg::*;
#(
  parameter int NUM_OUT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  qm_mode_e           mode,
  input  logic               data_in,
  input  logic [NUM_OUT-1:0] hit,
  output logic [NUM_OUT-1:0] outs
);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
    logic nxt;

    always_comb begin
      unique case (mode)
        MODE_WRITE:  nxt = hit[i] ? data_in : outs[i];
        MODE_HOLD:   nxt = outs[i];
        MODE_DECODE: nxt = hit[i] & data_in;
        default:     nxt = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) outs[i] <= 1'b0;
      else        outs[i] <= nxt;
    end
  end

endmodule

// File: rtl/qm_latch.sv
module qm_latch
  import qm_latch_pkg::*;
#(
  parameter int NUM_OUT = 8,
  localparam int ADDR_W = $clog2(NUM_OUT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_n,
  input  logic               clr_n,
  input  logic               data_in,
  input  logic [ADDR_W-1:0]  sel,
  output logic [NUM_OUT-1:0] outs
);

  qm_mode_e           mode;
  logic [NUM_OUT-1:0] hit;

  qm_mode_sel u_mode (
    .wr_en_n (wr_en_n),
    .clr_n   (clr_n),
    .mode    (mode)
  );

  qm_addr_dec #(
    .NUM_OUT (NUM_OUT),
    .ADDR_W  (ADDR_W)
  ) u_dec (
    .sel (sel),
    .hit (hit)
  );

  qm_out_bank #(
    .NUM_OUT (NUM_OUT)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .data_in (data_in),
    .hit     (hit),
    .outs    (outs)
  );

endmodule

// File: rtl/qm_latch_chk.sv
module qm_latch_chk #(
  parameter int NUM_OUT = 8,
  parameter int ADDR_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en_n,
  input logic               clr_n,
  input logic               data_in,
  input logic [ADDR_W-1:0]  sel,
  input logic [NUM_OUT-1:0] outs
);

  logic [NUM_OUT-1:0] sel_mask;
  assign sel_mask = NUM_OUT'(1) << sel;

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (outs == '0));

  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_n && clr_n) |=> (outs[$past(sel)] == $past(data_in)));

  p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_n && clr_n) |=> (((outs ^ $past(outs)) & ~$past(sel_mask)) == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_n && clr_n) |=> (outs == $past(outs)));

  p_decode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_n && !clr_n) |=> (outs == ($past(data_in) ? $past(sel_mask) : '0)));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_n && !clr_n) |=> (outs == '0));

  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_n && clr_n && $past(!wr_en_n && !clr_n)) |=> $onehot0(outs));

endmodule

bind qm_latch qm_latch_chk #(
  .NUM_OUT (NUM_OUT),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en_n (wr_en_n),
  .clr_n   (clr_n),
  .data_in (data_in),
  .sel     (sel),
  .outs    (outs)
);

// File: tb/test_qm_latch.sv
module test_qm_latch;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       wr_en_n = 1'b1;
  logic       clr_n = 1'b1;
  logic       data_in = 1'b0;
  logic [2:0] sel = '0;
  logic [7:0] outs;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] model = '0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  qm_latch i_qm_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_n (wr_en_n),
    .clr_n   (clr_n),
    .data_in (data_in),
    .sel     (sel),
    .outs    (outs)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outs=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Driver: one operation per cycle. The expected byte follows from the
  // mode rules and is queued for the monitor.
  task automatic op(logic en_n, logic c_n, logic d, logic [2:0] s, string tag);
    @(negedge clk);
    wr_en_n = en_n;
    clr_n   = c_n;
    data_in = d;
    sel     = s;
    #1;
    check({"R7 ", tag}, outs, model);  // no change between edges
    unique case ({en_n, c_n})
      2'b01: model[s] = d;
      2'b11: model = model;
      2'b00: model = d ? (8'd1 << s) : 8'd0;
      default: model = 8'd0;
    endcase
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares outputs shortly after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        string t;
        logic [7:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, outs, e);
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: outs=%b expected=run complete", outs);
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 check("R1 reset", outs, 8'h00);
    @(negedge clk) rst_n = 1'b1;

    // R9 / R6: serial load of 0xA5, select stepping 0..7
    for (int i = 0; i < 8; i++) op(1'b0, 1'b1, (8'hA5 >> i) & 1'b1, 3'(i), "R9 serial");
    @(posedge clk); #2 check("R9 byte", outs, 8'hA5);

    // R3: hold ignores data and select
    op(1'b1, 1'b1, 1'b1, 3'd1, "R3 hold");
    op(1'b1, 1'b1, 1'b0, 3'd0, "R3 hold");
    op(1'b1, 1'b1, 1'b1, 3'd6, "R3 hold");

    // R2: single-bit overwrites leave others alone
    op(1'b0, 1'b1, 1'b1, 3'd3, "R2 set");
    op(1'b0, 1'b1, 1'b0, 3'd7, "R2 clr");
    // R6: bit 0 of sel is the LSB
    op(1'b0, 1'b1, 1'b1, 3'd1, "R6 sel1");
    op(1'b0, 1'b1, 1'b0, 3'd4, "R6 sel4");

    // R4: decode sweep with data high, then data low
    for (int i = 0; i < 8; i++) op(1'b0, 1'b0, 1'b1, 3'(i), "R4 decode");
    op(1'b0, 1'b0, 1'b0, 3'd2, "R4 decode d0");

    // R8: decode then hold keeps the single bit
    op(1'b0, 1'b0, 1'b1, 3'd5, "R8 decode");
    op(1'b1, 1'b1, 1'b1, 3'd0, "R8 hold");
    op(1'b1, 1'b1, 1'b0, 3'd3, "R8 hold");
    @(posedge clk); #2 check("R8 pattern", outs, 8'h20);

    // R5: clear ignores data and select
    op(1'b0, 1'b1, 1'b1, 3'd0, "R2 set");
    op(1'b1, 1'b0, 1'b1, 3'd0, "R5 clear");
    op(1'b1, 1'b0, 1'b1, 3'd7, "R5 clear");

    // R1: power-on reset mid-run
    op(1'b0, 1'b1, 1'b1, 3'd2, "R2 set");
    op(1'b1, 1'b1, 1'b0, 3'd0, "R3 hold");
    @(posedge clk); #2;
    @(negedge clk) rst_n = 1'b0;
    #1 check("R1 async reset", outs, 8'h00);
    model = 8'h00;
    @(posedge clk); #2 check("R1 in reset", outs, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    op(1'b1, 1'b1, 1'b1, 3'd4, "R1 after reset");

    repeat (2) @(posedge clk);
    #3 finish_run();
  end

endmodule